// File: doc/BRIEF.md
# Video RAM Block Copier

This block moves data from memory into video RAM in units of sixteen bytes. Software sets up a 16-bit source address and a 16-bit destination address through four byte-wide address registers. It then writes a command byte that picks one of two modes. In the first mode the whole copy runs at once. In the second mode one sixteen-byte unit is copied on each horizontal-blank pulse, so the copying fits into the display's idle time.

The block drives a simple bus as its master. For each byte it issues a read request at the source address. Memory returns the data one cycle later, and the block writes it to the destination. While any byte is being moved, the stall output holds the processor. When a copy finishes, the block writes the final addresses back into the address registers, so a later command carries on from where the last one ended. The command register can be read back to see progress and completion.

Top module: `vram_blk_copier`

## Requirements
- R1: After reset the command readback is 0x00, `cpu_stall` is low and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: Register select codes: 0 = source high byte, 1 = source low byte, 2 = destination high byte, 3 = destination low byte, 4 = command. On a command write, the source is {high, low} with bits 3:0 cleared.
- R3: On a command write, the destination is ({high, low} AND 0x1FF0) OR 0x8000. While the copy runs, only bits 12:0 of the destination increment, so after 0x9FFF the next address is 0x8000.
- R4: A command write is ignored entirely if the aligned source lies in 0x8000–0x9FFF. Nothing is copied, the stall stays low and the command readback does not change.
- R5: Suppose a command write has bit 7 clear and no horizontal-blank mode is armed. Then a copy of (bits 6:0 + 1) × 16 bytes starts at once. `cpu_stall` rises in the cycle after the write and stays high for exactly two cycles per byte.
- R6: Each byte takes one read cycle and then one write cycle. In the read cycle `mem_rd_en` is high and `mem_addr` is the source. In the write cycle `mem_wr_en` is high, `mem_addr` is the destination, and `mem_wdata` equals the `mem_rdata` returned in that cycle. Both addresses then advance by one.
- R7: When a copy finishes, the four address registers hold the final source and destination. A new command written without any address writes continues from those addresses.
- R8: When an immediate copy finishes, the command readback is 0x80 OR the length field that was written.
- R9: A command write with bit 7 set arms horizontal-blank mode and copies nothing by itself; the readback then shows bits 6:0 of the write. Each `hblank_pulse` seen while armed and idle copies one 16-byte unit, continuing from the addresses where the previous unit ended, and then decrements the readback by one.
- R10: Horizontal-blank mode ends when the readback wraps from 0x00 to 0xFF, so exactly (bits 6:0 + 1) units are copied. Later pulses copy nothing.
- R11: A horizontal-blank pulse is ignored if the block is not armed or if a copy is already running.
- R12: A command write with bit 7 clear while horizontal-blank mode is armed disarms that mode and starts no copy. The readback then shows bits 6:0 of the write.
- R13: Any register write that arrives while `cpu_stall` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (codes in R2) |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Command register readback |
| hblank_pulse | input | 1 | One-cycle horizontal-blank pulse |
| mem_rd_en | output | 1 | Bus read request |
| mem_wr_en | output | 1 | Bus write request |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid one cycle after a read request |
| cpu_stall | output | 1 | Holds the processor while bytes move |

## Verification
The assertions rely on three things about the inputs. First, memory answers a read request with data in the very next cycle. Second, register writes and horizontal-blank pulses last one cycle each. Third, all inputs hold known values once reset has been released. The bench meets these conditions with a registered memory model that computes each byte from its address. It changes every input only on the falling edge and drops every strobe after one cycle. It also deliberately sends pulses and register writes while a copy is running, so that the ignore rules are exercised without breaking any of these conditions.

// File: rtl/vxe_pkg.sv
package vxe_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int UNIT_LOG2 = 4;
    localparam int CNT_W     = 7;
    localparam int VOFF_W    = 13;

    localparam logic [ADDR_W-1:0] VRAM_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] VRAM_END  = 16'hA000;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CMD    = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } addr_pair_t;

    function automatic logic [ADDR_W-1:0] align_src(input logic [7:0] hi, input logic [7:0] lo);
        logic [ADDR_W-1:0] a;
        a = {hi, lo};
        return {a[ADDR_W-1:UNIT_LOG2], {UNIT_LOG2{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] place_dst(input logic [7:0] hi, input logic [7:0] lo);
        logic [ADDR_W-1:0] a;
        a = {hi, lo};
        return VRAM_BASE | {{(ADDR_W-VOFF_W){1'b0}}, a[VOFF_W-1:UNIT_LOG2], {UNIT_LOG2{1'b0}}};
    endfunction

    function automatic logic in_vram(input logic [ADDR_W-1:0] a);
        return (a >= VRAM_BASE) && (a < VRAM_END);
    endfunction

    function automatic logic [ADDR_W-1:0] step_dst(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:VOFF_W], a[VOFF_W-1:0] + VOFF_W'(1)};
    endfunction

endpackage

// File: rtl/vxe_regs.sv
module vxe_regs
    import vxe_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [2:0]        sel_i,
    input  logic [7:0]        wdata_i,
    input  logic              hb_pulse_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  addr_pair_t        fin_i,
    output logic [7:0]        cmd_q_o,
    output logic              load_o,
    output logic              go_o,
    output logic [CW:0]       units_o,
    output addr_pair_t        start_o
);

    logic [7:0] src_hi, src_lo, dst_hi, dst_lo, cmd_q;
    logic       hb_armed;
    logic       wr_ok, cmd_wr, accept, want_hb, start_now, hb_go;

    assign wr_ok     = we_i && !busy_i;
    assign cmd_wr    = wr_ok && (reg_sel_e'(sel_i) == SEL_CMD);
    assign start_o   = '{src: align_src(src_hi, src_lo), dst: place_dst(dst_hi, dst_lo)};
    assign accept    = cmd_wr && !in_vram(start_o.src);
    assign want_hb   = wdata_i[7];
    assign start_now = accept && !want_hb && !hb_armed;
    assign hb_go     = hb_pulse_i && hb_armed && !busy_i && !accept;

    assign load_o    = accept && (want_hb || !hb_armed);
    assign go_o      = start_now || hb_go;
    assign units_o   = start_now ? ({1'b0, wdata_i[CW-1:0]} + (CW+1)'(1)) : (CW+1)'(1);
    assign cmd_q_o   = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_hi   <= '0;
            src_lo   <= '0;
            dst_hi   <= '0;
            dst_lo   <= '0;
            cmd_q    <= '0;
            hb_armed <= 1'b0;
        end else if (done_i) begin
            src_hi <= fin_i.src[15:8];
            src_lo <= fin_i.src[7:0];
            dst_hi <= fin_i.dst[15:8];
            dst_lo <= fin_i.dst[7:0];
            if (hb_armed) begin
                cmd_q <= cmd_q - 8'd1;
                if (cmd_q == 8'h00) begin
                    hb_armed <= 1'b0;
                end
            end else begin
                cmd_q[7] <= 1'b1;
            end
        end else if (wr_ok) begin
            case (reg_sel_e'(sel_i))
                SEL_SRC_HI: src_hi <= wdata_i;
                SEL_SRC_LO: src_lo <= wdata_i;
                SEL_DST_HI: dst_hi <= wdata_i;
                SEL_DST_LO: dst_lo <= wdata_i;
                SEL_CMD: begin
                    if (accept) begin
                        cmd_q    <= {1'b0, wdata_i[6:0]};
                        hb_armed <= want_hb;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vxe_mover.sv
module vxe_mover
    import vxe_pkg::*;
#(
    parameter int UL2 = UNIT_LOG2,
    parameter int CW  = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              go_i,
    input  logic [CW:0]       units_i,
    input  addr_pair_t        start_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              busy_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              done_o,
    output addr_pair_t        fin_o
);

    localparam int LEFT_W = CW + 1 + UL2;

    phase_e            phase;
    addr_pair_t        cur;
    logic [LEFT_W-1:0] left;

    assign fin_o   = '{src: cur.src + ADDR_W'(1), dst: step_dst(cur.dst)};
    assign busy_o  = (phase != PH_IDLE);
    assign rd_o    = (phase == PH_READ);
    assign wr_o    = (phase == PH_WRITE);
    assign done_o  = wr_o && (left == LEFT_W'(1));
    assign addr_o  = rd_o ? cur.src : (wr_o ? cur.dst : '0);
    assign wdata_o = wr_o ? rdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
            left  <= '0;
        end else begin
            if (load_i) begin
                cur <= start_i;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (go_i) begin
                        phase <= PH_READ;
                        left  <= LEFT_W'(units_i) << UL2;
                    end
                end
                PH_READ: phase <= PH_WRITE;
                PH_WRITE: begin
                    cur   <= fin_o;
                    left  <= left - LEFT_W'(1);
                    phase <= done_o ? PH_IDLE : PH_READ;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vram_blk_copier.sv
module vram_blk_copier
    import vxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              hblank_pulse,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cpu_stall
);

    logic            busy, done, load, go;
    logic [CNT_W:0]  units;
    addr_pair_t      fin, start;

    vxe_regs #(.CW(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (reg_we),
        .sel_i      (reg_sel),
        .wdata_i    (reg_wdata),
        .hb_pulse_i (hblank_pulse),
        .busy_i     (busy),
        .done_i     (done),
        .fin_i      (fin),
        .cmd_q_o    (ctrl_rdata),
        .load_o     (load),
        .go_o       (go),
        .units_o    (units),
        .start_o    (start)
    );

    vxe_mover #(.UL2(UNIT_LOG2), .CW(CNT_W)) u_mover (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .go_i    (go),
        .units_i (units),
        .start_i (start),
        .rdata_i (mem_rdata),
        .busy_o  (busy),
        .rd_o    (mem_rd_en),
        .wr_o    (mem_wr_en),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata),
        .done_o  (done),
        .fin_o   (fin)
    );

    assign cpu_stall = busy;

endmodule

// File: rtl/vxe_checker.sv
module vxe_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_stall,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [15:0] mem_addr,
    input logic [7:0]  ctrl_rdata
);

    a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> mem_wr_en);

    a_r6_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en));

    a_r5_bus_under_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> cpu_stall);

    a_r5_stall_opens_read: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> mem_rd_en);

    a_r3_dst_in_vram: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_addr[15:13] == 3'b100));

    a_r13_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |=> (!cpu_stall || $stable(ctrl_rdata)));

endmodule

bind vram_blk_copier vxe_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_stall  (cpu_stall),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .ctrl_rdata (ctrl_rdata)
);

// File: tb/vram_blk_copier_tb.sv
module vram_blk_copier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  ctrl_rdata;
    logic        hblank_pulse = 1'b0;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'd0;
    logic        cpu_stall;

    int n_chk = 0;
    int n_fail = 0;
    int nw = 0;
    int nstall = 0;
    int cyc = 0;
    logic [15:0] wa [0:4095];
    logic [7:0]  wd [0:4095];

    always #2 clk = ~clk;

    vram_blk_copier u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .hblank_pulse(hblank_pulse),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(mem_addr);
    end

    always @(negedge clk) begin
        if (mem_wr_en && nw < 4096) begin
            wa[nw] = mem_addr;
            wd[nw] = mem_wdata;
            nw = nw + 1;
        end
        if (cpu_stall) nstall = nstall + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        hblank_pulse = 1'b1;
        @(negedge clk);
        hblank_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && cpu_stall; i++) @(negedge clk);
    endtask

    task automatic clear_log();
        nw = 0;
        nstall = 0;
    endtask

    task automatic set_addrs(input logic [15:0] s, input logic [15:0] d);
        reg_write(3'd0, s[15:8]);
        reg_write(3'd1, s[7:0]);
        reg_write(3'd2, d[15:8]);
        reg_write(3'd3, d[7:0]);
    endtask

    task automatic verify(input string req, input int cnt, input logic [15:0] s, input logic [15:0] d);
        int bad = 0;
        for (int i = 0; i < cnt && i < nw; i++) begin
            logic [15:0] ea;
            ea = {3'b100, d[12:0] + 13'(i)};
            if (wa[i] !== ea || wd[i] !== pat(s + 16'(i))) bad++;
        end
        chk({req, " byte count"}, nw, cnt);
        chk({req, " addr/data mismatches"}, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 ctrl after reset", ctrl_rdata, 8'h00);
        chk("R1 stall after reset", cpu_stall, 1'b0);
        repeat (5) @(negedge clk);
        chk("R1 no bus writes", nw, 0);
    endtask

    task automatic t_general();
        set_addrs(16'h1234, 16'hE567);
        clear_log();
        reg_write(3'd4, 8'h01);
        chk("R5 stall rises after write", cpu_stall, 1'b1);
        wait_idle();
        verify("R2 R3 R6 general copy", 32, 16'h1230, 16'h8560);
        chk("R5 stall cycles", nstall, 64);
        chk("R8 ctrl after general", ctrl_rdata, 8'h81);
    endtask

    task automatic t_resume();
        clear_log();
        reg_write(3'd4, 8'h00);
        wait_idle();
        verify("R7 continue from writeback", 16, 16'h1250, 16'h8580);
        chk("R8 ctrl length 0", ctrl_rdata, 8'h80);
    endtask

    task automatic t_bad_src();
        set_addrs(16'h8800, 16'h8000);
        clear_log();
        reg_write(3'd4, 8'h03);
        repeat (20) @(negedge clk);
        chk("R4 no writes", nw, 0);
        chk("R4 no stall", nstall, 0);
        chk("R4 ctrl unchanged", ctrl_rdata, 8'h80);
    endtask

    task automatic t_hblank();
        set_addrs(16'h4000, 16'h0000);
        clear_log();
        reg_write(3'd4, 8'h82);
        repeat (10) @(negedge clk);
        chk("R9 armed no copy", nw, 0);
        chk("R9 armed readback", ctrl_rdata, 8'h02);
        pulse();
        wait_idle();
        verify("R9 unit 1", 16, 16'h4000, 16'h8000);
        chk("R9 unit stall", nstall, 32);
        chk("R9 count after unit 1", ctrl_rdata, 8'h01);
        clear_log();
        pulse();
        repeat (4) @(negedge clk);
        pulse();
        wait_idle();
        repeat (4) @(negedge clk);
        verify("R11 pulse during copy ignored", 16, 16'h4010, 16'h8010);
        chk("R9 count after unit 2", ctrl_rdata, 8'h00);
        clear_log();
        pulse();
        wait_idle();
        verify("R10 last unit", 16, 16'h4020, 16'h8020);
        chk("R10 wrap readback", ctrl_rdata, 8'hFF);
        clear_log();
        pulse();
        repeat (10) @(negedge clk);
        chk("R10 no copy after end", nw, 0);
    endtask

    task automatic t_wrap();
        set_addrs(16'h6000, 16'h1FF0);
        clear_log();
        reg_write(3'd4, 8'h01);
        wait_idle();
        verify("R3 destination wrap", 32, 16'h6000, 16'h9FF0);
        chk("R8 ctrl after wrap copy", ctrl_rdata, 8'h81);
    endtask

    task automatic t_cancel();
        set_addrs(16'h6000, 16'h8000);
        clear_log();
        reg_write(3'd4, 8'h85);
        chk("R9 armed readback", ctrl_rdata, 8'h05);
        reg_write(3'd4, 8'h07);
        repeat (20) @(negedge clk);
        chk("R12 cancel starts nothing", nw, 0);
        chk("R12 cancel readback", ctrl_rdata, 8'h07);
        pulse();
        repeat (10) @(negedge clk);
        chk("R11 pulse when unarmed", nw, 0);
    endtask

    task automatic t_busy_writes();
        set_addrs(16'h2000, 16'h0100);
        clear_log();
        reg_write(3'd4, 8'h00);
        reg_write(3'd4, 8'h05);
        reg_write(3'd0, 8'h30);
        wait_idle();
        repeat (10) @(negedge clk);
        verify("R13 writes during stall ignored", 16, 16'h2000, 16'h8100);
        chk("R13 ctrl readback", ctrl_rdata, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_general();
        t_resume();
        t_bad_src();
        t_hblank();
        t_wrap();
        t_cancel();
        t_busy_writes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule